// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

This block raises one active-low interrupt for a group of real-time status lines, for example two detector bits for each of four line channels. Each status bit passes through a synchroniser. A transition of an unmasked bit in either direction sets a change-pending latch. A second source is merged into the same interrupt: a strobe that marks new transmit data. This source sets a data-pending latch, but only while an arm bit is set.

Each latch holds until software reads the register that belongs to it. A read of the status register clears the change latch. A read of the transmit-data register clears the data latch. A software reset or the hardware reset clears both latches. Either reset also sets every bit of the per-bit mask register, so no status bit can interrupt until software unmasks it. The pin can be driven push-pull or as an open-drain output with a separate drive enable.

Top module: `cdi_irq_ctrl`

## Requirements
- R1: In push-pull mode (`od_mode_i`=0), `int_oe_o` is 1. `int_n_o` is 0 exactly when either latch is set, and 1 otherwise.
- R2: A 0-to-1 or a 1-to-0 change on `status_i[i]` sets the change latch when mask bit i is 0. `int_n_o` falls after the third rising clock edge that follows the change: two synchroniser stages, then the latch.
- R3: A write with `mask_wr_i`=1 loads `mask_wdata_i` into the mask register at the clock edge. Mask bit i set to 1 stops changes of status bit i from setting the change latch. Those changes are dropped, not kept for later.
- R4: A `txd_new_i` pulse sets the data latch only when `arm_i` is 1 in the same cycle. A pulse with `arm_i` at 0 has no effect.
- R5: A `rd_rtd_i` pulse clears the change latch at the clock edge and leaves the data latch unchanged.
- R6: A `rd_txd_i` pulse clears the data latch at the clock edge and leaves the change latch unchanged.
- R7: With no clearing read and no reset, a set latch stays set, even after its status bits stop changing.
- R8: When a new set condition and a clearing read for the same latch occur in one cycle, the latch stays set.
- R9: The hardware reset `rst` (synchronous, active high) clears both latches and sets all mask bits to 1.
- R10: `sw_rst_i` clears both latches and sets all mask bits to 1, as the hardware reset does.
- R11: In open-drain mode (`od_mode_i`=1), `int_oe_o` is 1 and `int_n_o` is 0 while a latch is set. `int_oe_o` is 0 while no latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst_i | input | 1 | Software reset pulse |
| status_i | input | 8 | Asynchronous real-time status bits |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask value; 1 masks the bit |
| arm_i | input | 1 | Enables the transmit-data interrupt source |
| txd_new_i | input | 1 | New transmit data strobe |
| rd_rtd_i | input | 1 | Status register read strobe |
| rd_txd_i | input | 1 | Transmit-data register read strobe |
| od_mode_i | input | 1 | 1 selects open-drain, 0 selects push-pull |
| int_n_o | output | 1 | Interrupt drive value, active low |
| int_oe_o | output | 1 | Pin drive enable |

## Verification
Assertions check on every clock cycle that a latch set and a clear in the same cycle leave the latch set, that a clear with no new cause empties the latch, and that an idle latch holds its value. They also check that an unarmed data strobe changes nothing, that the masks read all ones after either reset, and that the pin tracks the latches in both drive modes. Some behaviour is only visible in the bench scenarios: the three-edge latency of the synchroniser path, the handling of both edge polarities, the loss of changes on masked bits, and each read clearing only its own latch.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    localparam int unsigned CDI_CHANNELS    = 4;
    localparam int unsigned CDI_DET_PER_CH  = 2;
    localparam int unsigned CDI_STATUS_W    = CDI_CHANNELS * CDI_DET_PER_CH;
    localparam int unsigned CDI_SYNC_STAGES = 2;

    typedef enum logic {
        DRV_PUSH_PULL  = 1'b0,
        DRV_OPEN_DRAIN = 1'b1
    } cdi_drive_e;

    typedef struct packed {
        logic chg;
        logic dat;
    } cdi_pend_t;

    function automatic logic cdi_hit(input logic [CDI_STATUS_W-1:0] delta,
                                     input logic [CDI_STATUS_W-1:0] mask);
        return |(delta & ~mask);
    endfunction

endpackage

// File: rtl/cdi_sync.sv
module cdi_sync #(
    parameter int unsigned W      = cdi_pkg::CDI_STATUS_W,
    parameter int unsigned STAGES = cdi_pkg::CDI_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                prev_q  <= chain_q[LAST];
            end
        end

        assign sync_o[b] = chain_q[LAST];
        assign prev_o[b] = prev_q;
    end
endmodule

// File: rtl/cdi_change_latch.sv
module cdi_change_latch #(
    parameter int unsigned W = cdi_pkg::CDI_STATUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         clr_i,
    output logic         pend_o
);
    logic [W-1:0] mask_q;
    logic [W-1:0] delta;
    logic         hit;
    logic         pend_q;

    assign delta = cur_i ^ prev_i;
    assign hit   = cdi_pkg::cdi_hit(delta, mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_wr_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    logic was_rst_q;
    always_ff @(posedge clk) was_rst_q <= rst;

    // R8: a new change beats a simultaneous read
    a_r8_chg_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_i) |=> pend_q);
    // R5: a read with no new change empties the latch
    a_r5_chg_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit) |=> !pend_q);
    // R7: the latch holds while idle
    a_r7_chg_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !hit) |=> $stable(pend_q));
    // R9 / R10: every source masked right after any reset
    a_r9_mask_after_reset: assert property (@(posedge clk) disable iff (rst)
        was_rst_q |-> (&mask_q && !pend_q));
endmodule

// File: rtl/cdi_data_latch.sv
module cdi_data_latch (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic new_i,
    input  logic clr_i,
    output logic pend_o
);
    logic set_req;
    logic pend_q;

    assign set_req = arm_i & new_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (set_req) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R4: an unarmed strobe leaves the latch alone
    a_r4_unarmed_ignored: assert property (@(posedge clk) disable iff (rst)
        (new_i && !arm_i && !clr_i) |=> $stable(pend_q));
    // R6: a read with no armed strobe empties the latch
    a_r6_dat_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(new_i && arm_i)) |=> !pend_q);
    // R8: an armed strobe beats a simultaneous read
    a_r8_dat_set_wins: assert property (@(posedge clk) disable iff (rst)
        (new_i && arm_i) |=> pend_q);
endmodule

// File: rtl/cdi_pin_drive.sv
module cdi_pin_drive
    import cdi_pkg::*;
(
    input  cdi_pend_t  pend_i,
    input  cdi_drive_e mode_i,
    output logic       int_n_o,
    output logic       int_oe_o
);
    logic active;

    assign active  = pend_i.chg | pend_i.dat;
    assign int_n_o = ~active;

    always_comb begin
        unique case (mode_i)
            DRV_OPEN_DRAIN: int_oe_o = active;
            default:        int_oe_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/cdi_irq_ctrl.sv
module cdi_irq_ctrl
    import cdi_pkg::*;
#(
    parameter int unsigned STATUS_W = CDI_STATUS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_rst_i,
    input  logic [STATUS_W-1:0] status_i,
    input  logic                mask_wr_i,
    input  logic [STATUS_W-1:0] mask_wdata_i,
    input  logic                arm_i,
    input  logic                txd_new_i,
    input  logic                rd_rtd_i,
    input  logic                rd_txd_i,
    input  logic                od_mode_i,
    output logic                int_n_o,
    output logic                int_oe_o
);
    logic [STATUS_W-1:0] st_sync;
    logic [STATUS_W-1:0] st_prev;
    logic                clr_all;
    cdi_pend_t           pend;
    cdi_drive_e          mode;

    assign clr_all = rst | sw_rst_i;
    assign mode    = cdi_drive_e'(od_mode_i);

    cdi_sync #(.W(STATUS_W), .STAGES(CDI_SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (status_i),
        .sync_o  (st_sync),
        .prev_o  (st_prev)
    );

    cdi_change_latch #(.W(STATUS_W)) u_chg (
        .clk          (clk),
        .rst          (clr_all),
        .cur_i        (st_sync),
        .prev_i       (st_prev),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .clr_i        (rd_rtd_i),
        .pend_o       (pend.chg)
    );

    cdi_data_latch u_dat (
        .clk    (clk),
        .rst    (clr_all),
        .arm_i  (arm_i),
        .new_i  (txd_new_i),
        .clr_i  (rd_txd_i),
        .pend_o (pend.dat)
    );

    cdi_pin_drive u_pin (
        .pend_i   (pend),
        .mode_i   (mode),
        .int_n_o  (int_n_o),
        .int_oe_o (int_oe_o)
    );

    // R1: push-pull always drives, and the pin shows the pending state
    a_r1_push_pull: assert property (@(posedge clk) disable iff (rst)
        !od_mode_i |-> (int_oe_o && (int_n_o == !(pend.chg || pend.dat))));
    // R11: open drain releases the pin while idle and pulls low while pending
    a_r11_open_drain: assert property (@(posedge clk) disable iff (rst)
        od_mode_i |-> (int_oe_o == (pend.chg || pend.dat)) && (!int_oe_o || !int_n_o));
    // R10: software reset empties both latches
    a_r10_sw_reset: assert property (@(posedge clk) disable iff (rst)
        sw_rst_i |=> (!pend.chg && !pend.dat));
endmodule

// File: tb/cdi_irq_ctrl_test.sv
module cdi_irq_ctrl_test;
    localparam int NV = 31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst_i = 1'b0;
    logic [7:0] status_i = '0;
    logic       mask_wr_i = 1'b0;
    logic [7:0] mask_wdata_i = '0;
    logic       arm_i = 1'b0;
    logic       txd_new_i = 1'b0;
    logic       rd_rtd_i = 1'b0;
    logic       rd_txd_i = 1'b0;
    logic       od_mode_i = 1'b0;
    logic       int_n_o;
    logic       int_oe_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cdi_irq_ctrl uut (
        .clk(clk), .rst(rst), .sw_rst_i(sw_rst_i), .status_i(status_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .arm_i(arm_i),
        .txd_new_i(txd_new_i), .rd_rtd_i(rd_rtd_i), .rd_txd_i(rd_txd_i),
        .od_mode_i(od_mode_i), .int_n_o(int_n_o), .int_oe_o(int_oe_o)
    );

    // {status, mask_wr, mask_data, arm, new, rd_rtd, rd_txd, od, exp_int_n, exp_oe}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {8'h00, 1'b1, 8'h00, 7'b0000011},   // 0  unmask all
        {8'h01, 1'b0, 8'h00, 7'b0000011},   // 1  R2 rising change enters sync
        {8'h01, 1'b0, 8'h00, 7'b0000011},   // 2
        {8'h01, 1'b0, 8'h00, 7'b0000001},   // 3  R2 latched on third edge
        {8'h01, 1'b0, 8'h00, 7'b0000001},   // 4  R7 held
        {8'h01, 1'b0, 8'h00, 7'b0010011},   // 5  R5 status read clears
        {8'h00, 1'b0, 8'h00, 7'b0000011},   // 6  R2 falling change
        {8'h00, 1'b0, 8'h00, 7'b0000011},   // 7
        {8'h00, 1'b0, 8'h00, 7'b0000001},   // 8
        {8'h00, 1'b0, 8'h00, 7'b0010011},   // 9  R5
        {8'h00, 1'b1, 8'h02, 7'b0000011},   // 10 R3 mask bit 1
        {8'h02, 1'b0, 8'h00, 7'b0000011},   // 11 R3 masked change
        {8'h02, 1'b0, 8'h00, 7'b0000011},   // 12
        {8'h02, 1'b0, 8'h00, 7'b0000011},   // 13 R3 no interrupt
        {8'h02, 1'b0, 8'h00, 7'b0000011},   // 14 R3 change dropped
        {8'h02, 1'b0, 8'h00, 7'b0100011},   // 15 R4 unarmed strobe
        {8'h02, 1'b0, 8'h00, 7'b1100001},   // 16 R4 armed strobe
        {8'h02, 1'b0, 8'h00, 7'b1010001},   // 17 R6 status read keeps data
        {8'h02, 1'b0, 8'h00, 7'b0001011},   // 18 R6 data read clears
        {8'h02, 1'b0, 8'h00, 7'b0000110},   // 19 R11 idle released
        {8'h12, 1'b0, 8'h00, 7'b0000110},   // 20 R11
        {8'h12, 1'b0, 8'h00, 7'b0000110},   // 21
        {8'h12, 1'b0, 8'h00, 7'b0000101},   // 22 R11 pulled low
        {8'h12, 1'b0, 8'h00, 7'b1110101},   // 23 R5 R6 chg cleared, data set
        {8'h12, 1'b0, 8'h00, 7'b0001110},   // 24 R6 data read clears
        {8'h13, 1'b0, 8'h00, 7'b0000011},   // 25 R1 push-pull again
        {8'h13, 1'b0, 8'h00, 7'b0010011},   // 26
        {8'h13, 1'b0, 8'h00, 7'b0010001},   // 27 R8 change beats read
        {8'h13, 1'b0, 8'h00, 7'b0010011},   // 28 R5
        {8'h13, 1'b0, 8'h00, 7'b1101001},   // 29 R8 strobe beats read
        {8'h13, 1'b0, 8'h00, 7'b0001011}    // 30 R1
    };

    function automatic string row_req(input int i);
        if (i <= 9)  return "R2/R5/R7";
        if (i <= 14) return "R3";
        if (i <= 18) return "R4/R6";
        if (i <= 24) return "R11";
        return "R8/R1";
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic en, input logic eoe);
        checks++;
        if (int_n_o !== en || int_oe_o !== eoe) begin
            errors++;
            $display("FAIL %s: int_n=%b oe=%b expected int_n=%b oe=%b",
                     req, int_n_o, int_oe_o, en, eoe);
        end
    endtask

    task automatic idle();
        sw_rst_i = 0; mask_wr_i = 0; arm_i = 0; txd_new_i = 0;
        rd_rtd_i = 0; rd_txd_i = 0; od_mode_i = 0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        check("R9 reset state", 1'b1, 1'b1);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            status_i     = VEC[i][23:16];
            mask_wr_i    = VEC[i][15];
            mask_wdata_i = VEC[i][14:7];
            arm_i        = VEC[i][6];
            txd_new_i    = VEC[i][5];
            rd_rtd_i     = VEC[i][4];
            rd_txd_i     = VEC[i][3];
            od_mode_i    = VEC[i][2];
            step();
            check(row_req(i), VEC[i][1], VEC[i][0]);
        end
        idle();

        // R9: hardware reset clears pending data and masks every bit
        arm_i = 1; txd_new_i = 1; step(); idle();
        check("R4 pending before reset", 1'b0, 1'b1);
        rst = 1; step(); rst = 0;
        check("R9 reset clears latch", 1'b1, 1'b1);
        step(); step(); step();
        status_i = 8'h80; step(); step(); step(); step();
        check("R9 masked after reset", 1'b1, 1'b1);

        // R10: software reset
        mask_wr_i = 1; mask_wdata_i = 8'h00; step(); idle();
        status_i = 8'h00; step(); step(); step();
        check("R2 change after unmask", 1'b0, 1'b1);
        arm_i = 1; txd_new_i = 1; step(); idle();
        sw_rst_i = 1; step(); sw_rst_i = 0;
        check("R10 sw reset clears both", 1'b1, 1'b1);
        status_i = 8'h40; step(); step(); step(); step();
        check("R10 masked after sw reset", 1'b1, 1'b1);
        arm_i = 1; txd_new_i = 1; step(); idle();
        check("R4 data source after sw reset", 1'b0, 1'b1);
        rd_txd_i = 1; step(); idle();
        check("R6 final clear", 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule